// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This controller erases a single flash block and then proves that the block reads back as erased. It drives the control bits of a flash macro directly: a software-write enable, an erase setup bit, the erase pulse bit and an erase-verify bit. It also drives a watchdog enable and a small word-wide access port that is used during verify. A host pulses `start` with a one-hot block select. The sequencer then raises and lowers the control bits in a fixed order. After every bit change it waits a number of clock cycles given by a parameter. All waits share one down-counter.

During verify the sequencer steps through every word of the selected block, starting at its lowest address. For each word it issues a dummy all-ones write, waits, and reads one 16-bit word back. Any word that does not read as all ones ends the pass. The sequencer then repeats the erase pulse, up to a limit on the number of attempts. The run ends with a one-cycle `done` or `fail` pulse. An internal watchdog counter cuts off an erase pulse that runs too long.

Read data is expected on `fl_rdata` in the cycle after `fl_rd` is high. Block k starts at word address k × `WORDS_PER_BLOCK`.

Top module: `blk_erase_seq`

## Requirements
- R1: While and after reset, busy, done, fail, all control bits, wdog_en, fl_wr and fl_rd are low.
- R2: A start while idle whose blk_sel does not have exactly one bit set produces a fail pulse in the next cycle, leaves busy low and raises no control bit.
- R3: The order of control bits is as follows:
  - ctl_swe rises first.
  - wdog_en rises T_SWE_SET cycles later.
  - ctl_esu rises one cycle after wdog_en.
  - ctl_ers rises T_ESU_SET cycles after ctl_esu.
  - ctl_ers is only ever high while ctl_esu is high, and ctl_esu and ctl_ev are only ever high while ctl_swe is high.
- R4: wdog_en is high whenever ctl_esu is high. wdog_en falls T_ESU_CLR cycles after ctl_esu falls.
- R5: Each wait holds the bits unchanged for exactly its parameter in cycles:
  - ctl_ers stays high for T_ERASE cycles.
  - ctl_esu falls T_ERS_CLR cycles after ctl_ers falls.
  - ctl_ev rises T_ESU_CLR cycles after ctl_esu falls.
  - The first dummy write comes T_EV_SET cycles after ctl_ev rises.
  - Each read comes 1+T_VREAD cycles after its write.
  - ctl_swe falls T_EV_CLR cycles after ctl_ev falls.
  - done or fail comes T_SWE_CLR cycles after ctl_swe falls.
- R6: Verify writes 16'hFFFF with fl_wr and then reads with fl_rd. Both happen at the same address, which climbs by one from the block start. Only addresses inside the selected block are accessed.
- R7: If every word of the block reads 16'hFFFF, ctl_ev is cleared, then ctl_swe is cleared, and done pulses. This takes one erase pulse per attempt made.
- R8: A word that reads other than all ones ends the pass at that word. If fewer than MAX_TRIES attempts have failed, wdog_en rises again T_EV_CLR cycles after ctl_ev falls and a new erase pulse follows. After MAX_TRIES failed attempts, the run ends with a fail pulse.
- R9: If ctl_ers has been high for WDOG_LIMIT cycles, every control bit is low in the next cycle and fail pulses.
- R10: start is ignored while busy. The block in progress is not changed and no extra run follows.
- R11: done and fail are single-cycle pulses. Each appears in the first cycle that busy is low again.
- R12: fl_wr and fl_rd are never high together and are high only while ctl_ev is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to erase the selected block |
| blk_sel | input | NUM_BLOCKS | One-hot block select, sampled with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: block erased and verified |
| fail | output | 1 | One-cycle pulse: rejected request, retries exhausted or watchdog expiry |
| ctl_swe | output | 1 | Software-write enable to the flash macro |
| ctl_esu | output | 1 | Erase setup bit |
| ctl_ers | output | 1 | Erase pulse bit |
| ctl_ev | output | 1 | Erase-verify bit |
| wdog_en | output | 1 | Watchdog enable bracketing the erase pulse |
| fl_addr | output | ADDR_W | Word address for verify accesses |
| fl_wr | output | 1 | Dummy write strobe |
| fl_wdata | output | DATA_W | Dummy write data, all ones |
| fl_rd | output | 1 | Read strobe |
| fl_rdata | input | DATA_W | Read data, valid the cycle after fl_rd |

## Verification
A wrong internal state shows up at the ports right away, usually within one cycle. A state that skipped a wait, or stayed in one too long, moves the next control-bit edge off its expected cycle count. A verify walk that starts at the wrong base, or runs past the block end, shows up as an access outside the selected block. A wrong attempt count changes the number of erase pulses and the choice between done and fail. Those errors appear only at the end of the run, which is at most a few hundred cycles at bench timing.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SWE_ON, ST_ARM, ST_ESU_ON, ST_ERS_ON, ST_ERS_OFF, ST_ESU_OFF,
    ST_EV_ON, ST_DWR, ST_VWAIT, ST_VRD, ST_VCHK, ST_EV_OFF, ST_SWE_OFF
  } seq_state_e;

  typedef struct packed {
    logic busy;
    logic swe;
    logic dog;
    logic esu;
    logic ers;
    logic ev;
    logic wr;
    logic rd;
  } ctl_vec_t;

  // Output bits that hold in each state
  function automatic ctl_vec_t state_bits(seq_state_e s);
    ctl_vec_t v;
    v = '0;
    v.busy = (s != ST_IDLE);
    case (s)
      ST_SWE_ON:  v.swe = 1'b1;
      ST_ARM:     begin v.swe = 1'b1; v.dog = 1'b1; end
      ST_ESU_ON,
      ST_ERS_OFF: begin v.swe = 1'b1; v.dog = 1'b1; v.esu = 1'b1; end
      ST_ERS_ON:  begin v.swe = 1'b1; v.dog = 1'b1; v.esu = 1'b1; v.ers = 1'b1; end
      ST_ESU_OFF: begin v.swe = 1'b1; v.dog = 1'b1; end
      ST_EV_ON,
      ST_VWAIT,
      ST_VCHK:    begin v.swe = 1'b1; v.ev = 1'b1; end
      ST_DWR:     begin v.swe = 1'b1; v.ev = 1'b1; v.wr = 1'b1; end
      ST_VRD:     begin v.swe = 1'b1; v.ev = 1'b1; v.rd = 1'b1; end
      ST_EV_OFF:  v.swe = 1'b1;
      default:    ;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
  parameter int WAIT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              zero
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: an unloaded, non-empty count drops by exactly one per cycle
  assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/erase_addr_walker.sv
module erase_addr_walker #(
  parameter int ADDR_W = 12,
  parameter int SPAN   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] SPAN_M1 = ADDR_W'(SPAN - 1);

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr   <= '0;
    end else if (load) begin
      base_q <= base;
      addr   <= base;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign last = (addr == base_q + SPAN_M1);

  // R6: the walk never steps beyond the final word of the block
  assert_walk_bound_R6: assert property (@(posedge clk) disable iff (rst)
    step |-> !last);

endmodule

// File: rtl/erase_watchdog.sv
module erase_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic bite
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign bite = arm && (cnt == LAST);

endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 64,
  parameter int ADDR_W          = 12,
  parameter int DATA_W          = 16,
  parameter int WAIT_W          = 20,
  parameter int T_SWE_SET       = 25,
  parameter int T_ESU_SET       = 100,
  parameter int T_ERASE         = 500000,
  parameter int T_ERS_CLR       = 50,
  parameter int T_ESU_CLR       = 50,
  parameter int T_EV_SET        = 100,
  parameter int T_VREAD         = 10,
  parameter int T_EV_CLR        = 25,
  parameter int T_SWE_CLR       = 50,
  parameter int MAX_TRIES       = 100,
  parameter int WDOG_LIMIT      = 600000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_BLOCKS-1:0] blk_sel,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic                  ctl_swe,
  output logic                  ctl_esu,
  output logic                  ctl_ers,
  output logic                  ctl_ev,
  output logic                  wdog_en,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic                  fl_wr,
  output logic [DATA_W-1:0]     fl_wdata,
  output logic                  fl_rd,
  input  logic [DATA_W-1:0]     fl_rdata
);
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [DATA_W-1:0] ERASED   = '1;
  localparam logic [TRY_W-1:0]  TRY_LIM  = TRY_W'(MAX_TRIES);

  seq_state_e        state, nxt;
  ctl_vec_t          ctl;
  logic [IDX_W-1:0]  blk_idx;
  logic [TRY_W-1:0]  tries;
  logic              pass_q;
  logic              tmr_zero, tmr_load;
  logic [WAIT_W-1:0] tmr_val;
  logic              walk_load, walk_step, walk_last;
  logic [ADDR_W-1:0] walk_base;
  logic              bite;
  logic              sel_ok, accept, word_ok;
  logic              done_set, fail_set;

  function automatic logic [IDX_W-1:0] sel_index(input logic [NUM_BLOCKS-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_BLOCKS; i++)
      if (s[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Cycles spent in a state, minus one, loaded on entry
  function automatic logic [WAIT_W-1:0] hold_of(seq_state_e s);
    int t;
    case (s)
      ST_SWE_ON:  t = T_SWE_SET;
      ST_ESU_ON:  t = T_ESU_SET;
      ST_ERS_ON:  t = T_ERASE;
      ST_ERS_OFF: t = T_ERS_CLR;
      ST_ESU_OFF: t = T_ESU_CLR;
      ST_EV_ON:   t = T_EV_SET;
      ST_VWAIT:   t = T_VREAD;
      ST_EV_OFF:  t = T_EV_CLR;
      ST_SWE_OFF: t = T_SWE_CLR;
      default:    t = 1;
    endcase
    return WAIT_W'(t - 1);
  endfunction

  assign sel_ok  = ($countones(blk_sel) == 1);
  assign accept  = (state == ST_IDLE) && start && sel_ok;
  assign word_ok = (fl_rdata == ERASED);

  always_comb begin
    nxt      = state;
    done_set = 1'b0;
    fail_set = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start && sel_ok)  nxt = ST_SWE_ON;
        else if (start)       fail_set = 1'b1;
      end
      ST_SWE_ON:  if (tmr_zero) nxt = ST_ARM;
      ST_ARM:     nxt = ST_ESU_ON;
      ST_ESU_ON:  if (tmr_zero) nxt = ST_ERS_ON;
      ST_ERS_ON: begin
        if (bite) begin
          nxt      = ST_IDLE;
          fail_set = 1'b1;
        end else if (tmr_zero) begin
          nxt = ST_ERS_OFF;
        end
      end
      ST_ERS_OFF: if (tmr_zero) nxt = ST_ESU_OFF;
      ST_ESU_OFF: if (tmr_zero) nxt = ST_EV_ON;
      ST_EV_ON:   if (tmr_zero) nxt = ST_DWR;
      ST_DWR:     nxt = ST_VWAIT;
      ST_VWAIT:   if (tmr_zero) nxt = ST_VRD;
      ST_VRD:     nxt = ST_VCHK;
      ST_VCHK: begin
        if (word_ok && !walk_last) nxt = ST_DWR;
        else                       nxt = ST_EV_OFF;
      end
      ST_EV_OFF: begin
        if (tmr_zero) begin
          if (!pass_q && tries < TRY_LIM) nxt = ST_ARM;
          else                            nxt = ST_SWE_OFF;
        end
      end
      ST_SWE_OFF: begin
        if (tmr_zero) begin
          nxt      = ST_IDLE;
          done_set = pass_q;
          fail_set = !pass_q;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ctl     <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      tries   <= '0;
      pass_q  <= 1'b0;
      blk_idx <= '0;
    end else begin
      state <= nxt;
      ctl   <= state_bits(nxt);
      done  <= done_set;
      fail  <= fail_set;
      if (accept) begin
        blk_idx <= sel_index(blk_sel);
        tries   <= '0;
        pass_q  <= 1'b0;
      end else if (state == ST_VCHK) begin
        if (!word_ok)       tries  <= tries + 1'b1;
        else if (walk_last) pass_q <= 1'b1;
      end
    end
  end

  assign tmr_load  = (nxt != state);
  assign tmr_val   = hold_of(nxt);
  assign walk_load = (state == ST_ESU_OFF) && (nxt == ST_EV_ON);
  assign walk_base = ADDR_W'(blk_idx * WORDS_PER_BLOCK);
  assign walk_step = (state == ST_VCHK) && word_ok && !walk_last;

  erase_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  erase_addr_walker #(.ADDR_W(ADDR_W), .SPAN(WORDS_PER_BLOCK)) u_walk (
    .clk(clk), .rst(rst), .load(walk_load), .base(walk_base), .step(walk_step),
    .addr(fl_addr), .last(walk_last)
  );

  erase_watchdog #(.LIMIT(WDOG_LIMIT)) u_dog (
    .clk(clk), .rst(rst), .arm(ctl.ers), .bite(bite)
  );

  assign busy     = ctl.busy;
  assign ctl_swe  = ctl.swe;
  assign ctl_esu  = ctl.esu;
  assign ctl_ers  = ctl.ers;
  assign ctl_ev   = ctl.ev;
  assign wdog_en  = ctl.dog;
  assign fl_wr    = ctl.wr;
  assign fl_rd    = ctl.rd;
  assign fl_wdata = ERASED;

  // R3: nesting of the control bits
  assert_ers_under_esu_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_ers |-> ctl_esu);
  assert_swe_covers_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_esu || ctl_ev) |-> ctl_swe);
  // R4: watchdog covers the whole setup bit window
  assert_esu_under_dog_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_esu |-> wdog_en);
  // R12: verify accesses only inside the verify window, one at a time
  assert_bus_in_verify_R12: assert property (@(posedge clk) disable iff (rst)
    (fl_wr || fl_rd) |-> (ctl_ev && !(fl_wr && fl_rd)));
  // R11: completion pulses last one cycle and land when busy is low
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fail_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);
  assert_end_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);
  // R9: watchdog expiry drops every bit and reports failure
  assert_bite_abort_R9: assert property (@(posedge clk) disable iff (rst)
    bite |=> (!ctl_swe && !ctl_ers && !ctl_esu && fail));
  // R10: the selected block holds for the whole run
  assert_hold_block_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(blk_idx));

endmodule

// File: tb/blk_erase_seq_test.sv
`timescale 1ns/100ps
module blk_erase_seq_test;
  localparam int NB = 4, W = 4, AW = 6, DW = 16;
  localparam int TSW = 3, TESU = 2, TERS = 6, TECL = 2, TESUCL = 3;
  localparam int TEV = 2, TVR = 2, TEVCL = 2, TSWCL = 3, NTRY = 3;
  localparam int WDL = 20, WDL_SHORT = 4;
  // fields: [15:12] block select, [11:8] pulses needed, [7:4] failing word offset
  localparam logic [15:0] VEC [0:5] = '{
    16'h1120, 16'h2210, 16'h4330, 16'h8400, 16'h1230, 16'h8100 };

  logic clk = 0, rst = 1, start = 0;
  logic [NB-1:0] blk_sel = '0;
  logic busy, done, fail, swe, esu, ers, ev, dog, wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic start2 = 0;
  logic busy2, done2, fail2, swe2, esu2, ers2, ev2, dog2, wr2, rd2;
  logic [AW-1:0] addr2;
  logic [DW-1:0] wdata2;

  always #2.5 clk = ~clk;

  blk_erase_seq #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(W), .ADDR_W(AW), .DATA_W(DW),
    .WAIT_W(8), .T_SWE_SET(TSW), .T_ESU_SET(TESU), .T_ERASE(TERS), .T_ERS_CLR(TECL),
    .T_ESU_CLR(TESUCL), .T_EV_SET(TEV), .T_VREAD(TVR), .T_EV_CLR(TEVCL),
    .T_SWE_CLR(TSWCL), .MAX_TRIES(NTRY), .WDOG_LIMIT(WDL)) uut (
    .clk(clk), .rst(rst), .start(start), .blk_sel(blk_sel), .busy(busy), .done(done),
    .fail(fail), .ctl_swe(swe), .ctl_esu(esu), .ctl_ers(ers), .ctl_ev(ev),
    .wdog_en(dog), .fl_addr(addr), .fl_wr(wr), .fl_wdata(wdata), .fl_rd(rd),
    .fl_rdata(rdata));

  blk_erase_seq #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(W), .ADDR_W(AW), .DATA_W(DW),
    .WAIT_W(8), .T_SWE_SET(TSW), .T_ESU_SET(TESU), .T_ERASE(TERS), .T_ERS_CLR(TECL),
    .T_ESU_CLR(TESUCL), .T_EV_SET(TEV), .T_VREAD(TVR), .T_EV_CLR(TEVCL),
    .T_SWE_CLR(TSWCL), .MAX_TRIES(NTRY), .WDOG_LIMIT(WDL_SHORT)) uut_wd (
    .clk(clk), .rst(rst), .start(start2), .blk_sel(4'b0010), .busy(busy2), .done(done2),
    .fail(fail2), .ctl_swe(swe2), .ctl_esu(esu2), .ctl_ers(ers2), .ctl_ev(ev2),
    .wdog_en(dog2), .fl_addr(addr2), .fl_wr(wr2), .fl_wdata(wdata2), .fl_rd(rd2),
    .fl_rdata(16'h0000));

  // ---------------- flash model ----------------
  int m_base = 0, m_need = 1, m_bad = 0, m_pbase = 0;
  int pulses_tot = 0, reads_tot = 0, bad_acc = 0;
  logic ers_d = 0;
  always @(posedge clk) begin
    ers_d <= ers;
    if (ers_d && !ers) pulses_tot <= pulses_tot + 1;
    if ((wr || rd) && !ev) bad_acc <= bad_acc + 1;
    if (wr && (int'(addr) < m_base || int'(addr) >= m_base + W || wdata != 16'hFFFF))
      bad_acc <= bad_acc + 1;
    if (rd) begin
      reads_tot <= reads_tot + 1;
      if (int'(addr) < m_base || int'(addr) >= m_base + W) begin
        rdata   <= 16'h0BAD;
        bad_acc <= bad_acc + 1;
      end else if ((pulses_tot - m_pbase) < m_need && int'(addr) - m_base == m_bad)
        rdata <= 16'hFFFE;
      else
        rdata <= 16'hFFFF;
    end
  end

  // ---------------- timing monitor ----------------
  int cyc = 0, mchk = 0, merr = 0;
  int t_swe_r = 0, t_swe_f = 0, t_dog_r = 0, t_esu_r = 0, t_esu_f = 0;
  int t_ers_r = 0, t_ers_f = 0, t_ev_r = 0, t_ev_f = 0, t_wr = 0;
  logic p_swe = 0, p_dog = 0, p_esu = 0, p_ers = 0, p_ev = 0, p_wr = 0, p_rd = 0, p_end = 0;
  logic first_wr = 0;

  task automatic mon(bit ok, string req, int act, int exp);
    mchk++;
    if (!ok) begin
      merr++;
      $display("FAIL %s timing: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (swe && !p_swe) t_swe_r = cyc;
      if (dog && !p_dog) begin
        t_dog_r = cyc;
        if (t_ev_f > t_swe_r) mon(cyc - t_ev_f == TEVCL, "R8", cyc - t_ev_f, TEVCL);
        else                  mon(cyc - t_swe_r == TSW, "R3", cyc - t_swe_r, TSW);
      end
      if (esu && !p_esu) begin
        t_esu_r = cyc;
        mon(cyc - t_dog_r == 1, "R3", cyc - t_dog_r, 1);
      end
      if (ers && !p_ers) begin
        t_ers_r = cyc;
        mon(cyc - t_esu_r == TESU, "R3", cyc - t_esu_r, TESU);
      end
      if (!ers && p_ers) begin
        t_ers_f = cyc;
        mon(cyc - t_ers_r == TERS, "R5", cyc - t_ers_r, TERS);
      end
      if (!esu && p_esu) begin
        t_esu_f = cyc;
        mon(cyc - t_ers_f == TECL, "R5", cyc - t_ers_f, TECL);
      end
      if (!dog && p_dog) mon(cyc - t_esu_f == TESUCL, "R4", cyc - t_esu_f, TESUCL);
      if (ev && !p_ev) begin
        t_ev_r = cyc; first_wr = 1;
        mon(cyc - t_esu_f == TESUCL, "R5", cyc - t_esu_f, TESUCL);
      end
      if (wr && !p_wr) begin
        if (first_wr) mon(cyc - t_ev_r == TEV, "R5", cyc - t_ev_r, TEV);
        first_wr = 0; t_wr = cyc;
      end
      if (rd && !p_rd) mon(cyc - t_wr == 1 + TVR, "R6", cyc - t_wr, 1 + TVR);
      if (!ev && p_ev) t_ev_f = cyc;
      if (!swe && p_swe) begin
        t_swe_f = cyc;
        mon(cyc - t_ev_f == TEVCL, "R7", cyc - t_ev_f, TEVCL);
      end
      if ((done || fail) && !p_end && t_swe_f > 0 && t_swe_f > t_swe_r)
        mon(cyc - t_swe_f == TSWCL, "R5", cyc - t_swe_f, TSWCL);
    end
    p_swe = swe; p_dog = dog; p_esu = esu; p_ers = ers; p_ev = ev;
    p_wr = wr; p_rd = rd; p_end = done || fail;
  end

  // ---------------- main checks ----------------
  int checks = 0, errs = 0;
  bit hung = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks + mchk + (hung ? 1 : 0),
             errs + merr + (hung ? 1 : 0));
  endtask

  task automatic wait_end(output bit d, output bit f);
    d = 0; f = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done || fail) begin d = done; f = fail; break; end
    end
  endtask

  task automatic launch(input logic [NB-1:0] s);
    start = 1; blk_sel = s;
    @(negedge clk);
    start = 0; blk_sel = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    hung = 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    bit d, f;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, fail, swe, esu, ers, ev, dog, wr, rd} == '0, "R1 reset", 1, 0);
    rst = 0;
    @(negedge clk);
    chk({busy, done, fail, swe, esu, ers, ev, dog, wr, rd} == '0, "R1 after reset", 1, 0);

    // R2: rejected selects
    launch(4'b0000);
    chk(fail && !busy && !swe, "R2 empty select", {fail, busy, swe}, 3'b100);
    @(negedge clk);
    chk(!fail && !busy, "R2 pulse width", fail, 0);
    launch(4'b0110);
    chk(fail && !busy && !swe, "R2 two bits", {fail, busy, swe}, 3'b100);
    @(negedge clk);

    // vector table: R6 R7 R8
    foreach (VEC[k]) begin
      int idx, need, bad, pul, rds, p0, r0;
      bit pass;
      logic [NB-1:0] s;
      s = VEC[k][15:12]; need = int'(VEC[k][11:8]); bad = int'(VEC[k][7:4]);
      idx = 0;
      for (int i = 0; i < NB; i++) if (s[i]) idx = i;
      m_base = idx * W; m_need = need; m_bad = bad; m_pbase = pulses_tot;
      p0 = pulses_tot; r0 = reads_tot;
      pass = (need <= NTRY);
      pul  = pass ? need : NTRY;
      rds  = (pul - 1) * (bad + 1) + (pass ? W : bad + 1);
      launch(s);
      chk(busy, "R3 busy after start", busy, 1);
      wait_end(d, f);
      chk(d == pass && f == !pass, pass ? "R7 done" : "R8 fail", {d, f}, {pass, !pass});
      chk(!busy, "R11 busy low at end", busy, 0);
      @(negedge clk);
      chk(!done && !fail, "R11 single pulse", {done, fail}, 0);
      chk(pulses_tot - p0 == pul, "R8 erase pulses", pulses_tot - p0, pul);
      chk(reads_tot - r0 == rds, "R6 verify reads", reads_tot - r0, rds);
      chk(bad_acc == 0, "R6 access in block", bad_acc, 0);
    end

    // R10: start while busy is ignored
    m_base = 0; m_need = 1; m_bad = 0; m_pbase = pulses_tot;
    begin
      int r0, p0;
      r0 = reads_tot; p0 = pulses_tot;
      launch(4'b0001);
      repeat (5) @(negedge clk);
      launch(4'b0100);
      wait_end(d, f);
      chk(d && !f, "R10 run completes", {d, f}, 2'b10);
      chk(reads_tot - r0 == W, "R10 original block only", reads_tot - r0, W);
      repeat (4) @(negedge clk);
      chk(!busy && pulses_tot - p0 == 1, "R10 no second run", pulses_tot - p0, 1);
      chk(bad_acc == 0, "R12 bus only in verify and block", bad_acc, 0);
    end

    // R9: watchdog expiry on the short-limit instance
    begin
      int hi;
      hi = 0;
      start2 = 1;
      @(negedge clk);
      start2 = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (ers2) hi++;
        else if (hi > 0) break;
      end
      chk(hi == WDL_SHORT, "R9 erase cut length", hi, WDL_SHORT);
      chk(fail2 && !swe2 && !esu2 && !dog2 && !ev2 && !busy2, "R9 bits cleared and fail",
          {fail2, swe2, esu2, dog2, ev2, busy2}, 6'b100000);
      @(negedge clk);
      chk(!fail2 && !done2, "R11 watchdog fail pulse", fail2, 0);
    end

    report();
    $finish;
  end

endmodule